// File: doc/BRIEF.md
# CPU Clock Power-State Controller

This block decides what the processor clock does. The clock is always in one of three states: full speed, slow (divided by a programmable amount), or stopped. Two inactivity timers, a HALT detector and a software command port can each move the clock toward a lower-power state. A wake input assigned to each low-power state, or software, brings it back. Any activity pulse reloads both timers. Timer A leads to slow mode and timer B leads to the stopped state.

The block issues a divisor and a clock-run output for the clock generator. It also has a stop-clock request with an acknowledge input for a handshake with the processor, and a stop output for an external clock chip. Three inputs choose the behaviour: the switching method, the divisor, and the HALT policy. A separate interrupt block receives one-cycle strobes for timer expiry, HALT detection and accepted wake events.

Top module: `cpu_clk_power_ctl`

## Requirements
- R1: After reset the state is full speed (state_o = 0), clk_div_o = 0, clk_run_o = 1, and stpclk_req_o, ext_stop_o and all strobes are 0.
- R2: With a nonzero reload value R, a timer's expiry strobe goes high for exactly one cycle, R cycles after the last activity pulse it sampled. A new activity pulse restarts the count. A reload value of 0 disables the timer, so it never strobes.
- R3: A timer A expiry while at full speed moves the state to slow (state_o = 1). In the slow state, clk_div_o equals slow_div_i. In every other state clk_div_o is 0.
- R4: A timer B expiry while at full speed or slow moves the state to stopped (state_o = 2).
- R5: A HALT pulse always produces a one-cycle halt_det_o strobe. When halt_slow_only_i = 0, a HALT stops the clock from full speed or slow. When halt_slow_only_i = 1, a HALT stops the clock only from slow and has no effect at full speed.
- R6: wake_a_i returns the clock from slow to full speed and has no effect while stopped. wake_b_i returns the clock from stopped to full speed.
- R7: A software command is sampled when cmd_valid_i = 1. The codes are: cmd_i = 1 selects full speed, 2 selects slow, 3 selects stopped, and 0 does nothing.
- R8: If a wake that applies to the current state arrives in the same cycle as a software command or a timer or HALT event, the wake wins and the target is full speed.
- R9: In handshake mode (switch_mode_i = 1), a transition first raises stpclk_req_o and holds the state. The state changes, and the request drops, on the edge that samples stpclk_ack_i high.
- R10: In handshake mode with no acknowledge, the transition completes after ACK_TIMEOUT cycles of request.
- R11: In external-stop mode (switch_mode_i = 2), the stopped state drives ext_stop_o = 1 and keeps clk_run_o = 1. In modes 0, 1 and 3 the stopped state drives clk_run_o = 0 and ext_stop_o = 0. Modes 0, 2 and 3 switch on the edge that samples the event.
- R12: wake_o strobes for one cycle when a wake causes a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| activity_i | input | 1 | System activity pulse, reloads both timers |
| halt_i | input | 1 | HALT cycle detected pulse |
| wake_a_i | input | 1 | Wake event for the slow state |
| wake_b_i | input | 1 | Wake event for the stopped state |
| cmd_valid_i | input | 1 | Software command strobe |
| cmd_i | input | 2 | Command code: 0 none, 1 full, 2 slow, 3 stop |
| reload_a_i | input | TMR_W | Timer A reload value, 0 disables |
| reload_b_i | input | TMR_W | Timer B reload value, 0 disables |
| slow_div_i | input | DIV_W | Divisor used in the slow state |
| halt_slow_only_i | input | 1 | HALT stops the clock only from slow |
| switch_mode_i | input | 2 | 0 instant, 1 handshake, 2 external stop, 3 instant |
| stpclk_ack_i | input | 1 | Processor acknowledge of the stop-clock request |
| state_o | output | 2 | Current state: 0 full, 1 slow, 2 stopped |
| clk_div_o | output | DIV_W | Divisor for the clock generator, 0 at full speed |
| clk_run_o | output | 1 | Clock gate enable |
| stpclk_req_o | output | 1 | Stop-clock handshake request |
| ext_stop_o | output | 1 | Stop output for an external clock generator |
| tmr_a_exp_o | output | 1 | Timer A expiry strobe |
| tmr_b_exp_o | output | 1 | Timer B expiry strobe |
| halt_det_o | output | 1 | HALT detection strobe |
| wake_o | output | 1 | Accepted wake strobe |

## Verification
The bench measures the exact expiry latency of each timer, both after a single activity pulse and after a pulse that reloads the count partway through. A counter that is off by one, or that ignores reloads, shows up as a wrong latency. It drives a wake in the same cycle as a conflicting command and checks that the clock goes to full speed, so that a wrong priority order would be caught. It also checks the HALT policy at full speed in both settings, sends a wake to a state that should ignore it, and measures the request length on a handshake timeout, where an early or late switch or a stuck request would be reported.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic [1:0] {
    PS_FULL = 2'd0,
    PS_SLOW = 2'd1,
    PS_STOP = 2'd2
  } pstate_e;

  typedef enum logic [1:0] {
    SM_INSTANT   = 2'd0,
    SM_HANDSHAKE = 2'd1,
    SM_EXTPIN    = 2'd2,
    SM_SPARE     = 2'd3
  } swmode_e;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_FULL = 2'd1;
  localparam logic [1:0] CMD_SLOW = 2'd2;
  localparam logic [1:0] CMD_STOP = 2'd3;

  function automatic pstate_e cmd_target(input logic [1:0] code);
    case (code)
      CMD_SLOW: return PS_SLOW;
      CMD_STOP: return PS_STOP;
      default:  return PS_FULL;
    endcase
  endfunction

endpackage

// File: rtl/cpm_idle_timer.sv
module cpm_idle_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activity_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic             expire_o
);

  logic [TMR_W-1:0] cnt_q;
  logic             at_last;

  function automatic logic [TMR_W-1:0] step_down(input logic [TMR_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  assign at_last = (cnt_q == TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (reload_i == '0) begin
        cnt_q <= '0;
      end else if (activity_i) begin
        cnt_q <= reload_i;
      end else if (at_last) begin
        cnt_q    <= '0;
        expire_o <= 1'b1;
      end else begin
        cnt_q <= step_down(cnt_q);
      end
    end
  end

  AST_EXPIRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R2

  AST_ZERO_RELOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reload_i) == '0) |-> !expire_o); // R2

endmodule

// File: rtl/cpm_state_arbiter.sv
module cpm_state_arbiter
  import cpm_pkg::*;
(
  input  pstate_e    cur_i,
  input  logic       wake_a_i,
  input  logic       wake_b_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       tmr_a_exp_i,
  input  logic       tmr_b_exp_i,
  input  logic       halt_i,
  input  logic       halt_slow_only_i,
  output logic       go_o,
  output pstate_e    tgt_o,
  output logic       wake_take_o
);

  logic wake_hit;
  logic cmd_hit;
  logic halt_hit;

  assign wake_hit = (cur_i == PS_SLOW && wake_a_i) || (cur_i == PS_STOP && wake_b_i);
  assign cmd_hit  = cmd_valid_i && (cmd_i != CMD_NONE) && (cmd_target(cmd_i) != cur_i);
  assign halt_hit = halt_i && ((cur_i == PS_SLOW) ||
                               (cur_i == PS_FULL && !halt_slow_only_i));

  always_comb begin
    go_o        = 1'b0;
    tgt_o       = cur_i;
    wake_take_o = 1'b0;
    if (wake_hit) begin
      go_o        = 1'b1;
      tgt_o       = PS_FULL;
      wake_take_o = 1'b1;
    end else if (cmd_hit) begin
      go_o  = 1'b1;
      tgt_o = cmd_target(cmd_i);
    end else if (tmr_b_exp_i && cur_i != PS_STOP) begin
      go_o  = 1'b1;
      tgt_o = PS_STOP;
    end else if (halt_hit) begin
      go_o  = 1'b1;
      tgt_o = PS_STOP;
    end else if (tmr_a_exp_i && cur_i == PS_FULL) begin
      go_o  = 1'b1;
      tgt_o = PS_SLOW;
    end
  end

endmodule

// File: rtl/cpm_switch_seq.sv
module cpm_switch_seq
  import cpm_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_i,
  input  pstate_e tgt_i,
  input  swmode_e mode_i,
  input  logic    ack_i,
  output pstate_e cur_o,
  output logic    busy_o
);

  localparam int CW = $clog2(ACK_TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_TIMEOUT - 1);

  pstate_e        tgt_q;
  logic [CW-1:0]  wcnt_q;
  logic           wait_done;

  assign wait_done = ack_i || (wcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o  <= PS_FULL;
      tgt_q  <= PS_FULL;
      busy_o <= 1'b0;
      wcnt_q <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        if (mode_i == SM_HANDSHAKE) begin
          busy_o <= 1'b1;
          tgt_q  <= tgt_i;
          wcnt_q <= '0;
        end else begin
          cur_o <= tgt_i;
        end
      end
    end else if (wait_done) begin
      cur_o  <= tgt_q;
      busy_o <= 1'b0;
      wcnt_q <= '0;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  AST_REQ_DROP_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (cur_o != $past(cur_o))); // R9

  AST_HOLD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ack_i && wcnt_q != LAST) |=> ($stable(cur_o) && busy_o)); // R9

  AST_TIMEOUT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wcnt_q == LAST) |=> !busy_o); // R10

endmodule

// File: rtl/cpu_clk_power_ctl.sv
module cpu_clk_power_ctl
  import cpm_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int DIV_W       = 4,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activity_i,
  input  logic             halt_i,
  input  logic             wake_a_i,
  input  logic             wake_b_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_i,
  input  logic [TMR_W-1:0] reload_a_i,
  input  logic [TMR_W-1:0] reload_b_i,
  input  logic [DIV_W-1:0] slow_div_i,
  input  logic             halt_slow_only_i,
  input  logic [1:0]       switch_mode_i,
  input  logic             stpclk_ack_i,
  output logic [1:0]       state_o,
  output logic [DIV_W-1:0] clk_div_o,
  output logic             clk_run_o,
  output logic             stpclk_req_o,
  output logic             ext_stop_o,
  output logic             tmr_a_exp_o,
  output logic             tmr_b_exp_o,
  output logic             halt_det_o,
  output logic             wake_o
);

  localparam int NUM_TMR = 2;

  logic [TMR_W-1:0] reload_v [NUM_TMR];
  logic             expire_v [NUM_TMR];

  assign reload_v[0] = reload_a_i;
  assign reload_v[1] = reload_b_i;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    cpm_idle_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .activity_i (activity_i),
      .reload_i   (reload_v[g]),
      .expire_o   (expire_v[g])
    );
  end

  assign tmr_a_exp_o = expire_v[0];
  assign tmr_b_exp_o = expire_v[1];

  swmode_e mode;
  pstate_e cur;
  pstate_e arb_tgt;
  logic    arb_go;
  logic    arb_wake;
  logic    seq_busy;
  logic    wake_accept;

  assign mode = swmode_e'(switch_mode_i);

  cpm_state_arbiter u_arb (
    .cur_i            (cur),
    .wake_a_i         (wake_a_i),
    .wake_b_i         (wake_b_i),
    .cmd_valid_i      (cmd_valid_i),
    .cmd_i            (cmd_i),
    .tmr_a_exp_i      (expire_v[0]),
    .tmr_b_exp_i      (expire_v[1]),
    .halt_i           (halt_i),
    .halt_slow_only_i (halt_slow_only_i),
    .go_o             (arb_go),
    .tgt_o            (arb_tgt),
    .wake_take_o      (arb_wake)
  );

  cpm_switch_seq #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (arb_go),
    .tgt_i  (arb_tgt),
    .mode_i (mode),
    .ack_i  (stpclk_ack_i),
    .cur_o  (cur),
    .busy_o (seq_busy)
  );

  assign wake_accept = arb_go && arb_wake && !seq_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_det_o <= 1'b0;
      wake_o     <= 1'b0;
    end else begin
      halt_det_o <= halt_i;
      wake_o     <= wake_accept;
    end
  end

  function automatic logic [DIV_W-1:0] div_for(input pstate_e s, input logic [DIV_W-1:0] d);
    return (s == PS_SLOW) ? d : '0;
  endfunction

  assign state_o      = cur;
  assign clk_div_o    = div_for(cur, slow_div_i);
  assign stpclk_req_o = seq_busy;
  assign ext_stop_o   = (cur == PS_STOP) && (mode == SM_EXTPIN);
  assign clk_run_o    = !((cur == PS_STOP) && (mode != SM_EXTPIN));

  AST_WAKE_B_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == PS_STOP && wake_b_i && !seq_busy && mode != SM_HANDSHAKE) |=> (cur == PS_FULL)); // R6

  AST_WAKE_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == PS_SLOW && wake_a_i && !seq_busy && mode != SM_HANDSHAKE) |=> (cur == PS_FULL)); // R8

  AST_WAKE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (cur == PS_FULL || seq_busy)); // R12

endmodule

// File: tb/cpu_clk_power_ctl_bench.sv
module cpu_clk_power_ctl_bench;

  localparam int PERIOD = 10;
  localparam int TW     = 16;
  localparam int DW     = 4;
  localparam int ACK_TO = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          activity = 1'b0, halt = 1'b0, wake_a = 1'b0, wake_b = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd = 2'd0;
  logic [TW-1:0] rel_a = '0, rel_b = '0;
  logic [DW-1:0] sdiv = 4'd5;
  logic          slow_only = 1'b0;
  logic [1:0]    smode = 2'd0;
  logic          ack = 1'b0;
  logic [1:0]    state;
  logic [DW-1:0] cdiv;
  logic          run, req, xstop, ea, eb, hdet, wk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cpu_clk_power_ctl #(.TMR_W(TW), .DIV_W(DW), .ACK_TIMEOUT(ACK_TO)) u_cpu_clk_power_ctl (
    .clk(clk), .rst_n(rst_n), .activity_i(activity), .halt_i(halt),
    .wake_a_i(wake_a), .wake_b_i(wake_b), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .reload_a_i(rel_a), .reload_b_i(rel_b), .slow_div_i(sdiv),
    .halt_slow_only_i(slow_only), .switch_mode_i(smode), .stpclk_ack_i(ack),
    .state_o(state), .clk_div_o(cdiv), .clk_run_o(run), .stpclk_req_o(req),
    .ext_stop_o(xstop), .tmr_a_exp_o(ea), .tmr_b_exp_o(eb), .halt_det_o(hdet),
    .wake_o(wk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = 2'd0;
  endtask

  task automatic pulse_act();
    @(negedge clk); activity = 1'b1;
    @(negedge clk); activity = 1'b0;
  endtask

  task automatic pulse_wake_a();
    @(negedge clk); wake_a = 1'b1;
    @(negedge clk); wake_a = 1'b0;
  endtask

  task automatic pulse_wake_b();
    @(negedge clk); wake_b = 1'b1;
    @(negedge clk); wake_b = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 div", cdiv, 0);
    chk("R1 run", run, 1);
    chk("R1 req", req, 0);
    chk("R1 ext_stop", xstop, 0);
    chk("R1 strobes", {ea, eb, hdet, wk}, 0);
  endtask

  task automatic t_timer_a();
    int lat;
    rel_a = 16'd5;
    pulse_act();
    lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); lat++;
      if (ea) break;
    end
    chk("R2 timer A latency", lat, 5);
    @(negedge clk);
    chk("R2 strobe one cycle", ea, 0);
    chk("R3 slow state", state, 1);
    chk("R3 slow divisor", cdiv, sdiv);
    rel_a = '0;
    pulse_wake_a();
    chk("R6 wake A to full", state, 0);
    chk("R12 wake strobe", wk, 1);
    @(negedge clk);
    chk("R12 wake strobe ends", wk, 0);
    chk("R3 full divisor", cdiv, 0);
  endtask

  task automatic t_reload();
    int lat;
    int early;
    rel_a = 16'd8;
    pulse_act();
    early = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); if (ea) early++;
    end
    pulse_act();
    lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); lat++;
      if (ea) break;
    end
    chk("R2 no strobe before reload", early, 0);
    chk("R2 latency after reload", lat, 8);
    rel_a = '0;
    @(negedge clk);
    pulse_wake_a();
    chk("R6 back to full", state, 0);
  endtask

  task automatic t_zero_reload();
    int seen;
    rel_a = '0; rel_b = '0;
    pulse_act();
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (ea || eb) seen++;
    end
    chk("R2 zero reload silent", seen, 0);
    chk("R2 zero reload state", state, 0);
  endtask

  task automatic t_timer_b();
    int lat;
    rel_b = 16'd4;
    pulse_act();
    lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); lat++;
      if (eb) break;
    end
    chk("R2 timer B latency", lat, 4);
    @(negedge clk);
    rel_b = '0;
    chk("R4 stopped", state, 2);
    chk("R11 run low when stopped", run, 0);
    chk("R11 ext stop low in instant", xstop, 0);
    pulse_wake_a();
    chk("R6 wake A ignored in stop", state, 2);
    chk("R12 no strobe for ignored wake", wk, 0);
    pulse_wake_b();
    chk("R6 wake B restarts", state, 0);
    chk("R6 run restored", run, 1);
  endtask

  task automatic t_halt();
    slow_only = 1'b0;
    pulse_halt();
    chk("R5 halt strobe", hdet, 1);
    chk("R5 unconditional halt stops", state, 2);
    pulse_wake_b();
    slow_only = 1'b1;
    pulse_halt();
    chk("R5 halt strobe slow-only", hdet, 1);
    chk("R5 halt ignored at full", state, 0);
    send_cmd(2'd2);
    chk("R7 cmd slow", state, 1);
    pulse_halt();
    chk("R5 halt stops from slow", state, 2);
    pulse_wake_b();
    slow_only = 1'b0;
  endtask

  task automatic t_cmds();
    send_cmd(2'd3);
    chk("R7 cmd stop", state, 2);
    send_cmd(2'd1);
    chk("R7 cmd full", state, 0);
    send_cmd(2'd0);
    chk("R7 cmd none", state, 0);
    send_cmd(2'd2);
    chk("R7 cmd slow", state, 1);
    send_cmd(2'd0);
    chk("R7 cmd none keeps slow", state, 1);
    send_cmd(2'd1);
    chk("R7 cmd full again", state, 0);
  endtask

  task automatic t_priority();
    send_cmd(2'd2);
    @(negedge clk); wake_a = 1'b1; cmd_valid = 1'b1; cmd = 2'd3; halt = 1'b1;
    @(negedge clk); wake_a = 1'b0; cmd_valid = 1'b0; cmd = 2'd0; halt = 1'b0;
    chk("R8 wake A beats cmd", state, 0);
    send_cmd(2'd3);
    @(negedge clk); wake_b = 1'b1; cmd_valid = 1'b1; cmd = 2'd2;
    @(negedge clk); wake_b = 1'b0; cmd_valid = 1'b0; cmd = 2'd0;
    chk("R8 wake B beats cmd", state, 0);
  endtask

  task automatic t_handshake();
    int n;
    smode = 2'd1;
    send_cmd(2'd3);
    chk("R9 request raised", req, 1);
    chk("R9 state held", state, 0);
    repeat (3) @(negedge clk);
    chk("R9 still waiting", state, 0);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 state after ack", state, 2);
    chk("R9 request dropped", req, 0);
    pulse_wake_b();
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (!req) break;
      n++;
      @(negedge clk);
    end
    chk("R10 timeout length", n, ACK_TO);
    chk("R10 state after timeout", state, 0);
    smode = 2'd0;
  endtask

  task automatic t_extpin();
    smode = 2'd2;
    send_cmd(2'd3);
    chk("R11 ext stopped state", state, 2);
    chk("R11 ext stop high", xstop, 1);
    chk("R11 run kept high", run, 1);
    pulse_wake_b();
    chk("R11 ext stop released", xstop, 0);
    smode = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer_a();
    t_reload();
    t_zero_reload();
    t_timer_b();
    t_halt();
    t_cmds();
    t_priority();
    t_handshake();
    t_extpin();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule